// File: doc/BRIEF.md
# TDM Audio Serial Port (Slave)

This block is a full-duplex serial port for time-division-multiplexed audio streams. An external master supplies the bit clock and the frame sync. Each frame carries a fixed number of 16-bit time slots, one per cascaded converter channel. On the receive side the port collects one word per slot and hands it to the system with its slot number. On the transmit side it takes one word per slot from the system and shifts it out, most significant bit first.

The parallel side runs on a fast system clock that has no fixed relation to the bit clock. The bit clock, frame sync and serial input are brought into the system clock domain through synchroniser chains. All serial timing is then derived from edges of the synchronised bit clock. The system clock must be at least eight times faster than the bit clock.

A frame begins when the frame sync is sampled high on a falling bit-clock edge. The first data bit follows one bit clock later. Frames may follow each other with no gap: the next sync then lines up with the last bit of the previous frame. A sync that arrives anywhere else inside a frame restarts the slot count. A missing transmit word is replaced by silence.

Top module: `tdm_slave_port`

## Requirements
- R1: Each received word is 16 bits, assembled MSB first, and is presented on `rx_word_o` with its slot number on `rx_slot_o`. Within a frame the slot numbers run 0, 1, ... SLOTS-1 in order.
- R2: Frame timing uses a one-bit data delay. When `fsync_i` is sampled high on a falling edge of `bclk_i`, the MSB of slot 0 is sampled on the next falling edge. The transmit MSB of slot 0 is driven after the next rising edge.
- R3: `sdout_o` changes only after a rising edge of `bclk_i` and holds through the whole low phase. `sdin_i` is sampled at falling edges only.
- R4: Before the first frame sync, and after the last bit of a frame when no new sync has been seen, `sdout_o` is 0 and no received word is produced.
- R5: A frame sync sampled together with the last bit of the last slot is not an error. That last word is delivered, and the next frame starts at slot 0.
- R6: A frame sync sampled at any other bit inside a frame drops the partly received word and restarts at slot 0 bit 15. It also sets `sync_err_o`, which stays set until reset.
- R7: If no transmit word is held when a slot starts, the port sends 16 zero bits and pulses `tx_underrun_o` high for one system clock.
- R8: `tx_ready_o` is high exactly when the one-word transmit holding register is empty. Accepted words are sent in acceptance order, one per slot start.
- R9: `rx_valid_o` stays high with its word and slot stable until `rx_ready_i` accepts it. A newer word completed before acceptance replaces the held one.
- R10: After reset, `rx_valid_o`, `sdout_o`, `tx_underrun_o` and `sync_err_o` are 0 and `tx_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the parallel side and all logic |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bclk_i | input | 1 | Serial bit clock from the external master |
| fsync_i | input | 1 | Active-high frame sync from the external master |
| sdin_i | input | 1 | Serial receive data |
| sdout_o | output | 1 | Serial transmit data |
| rx_valid_o | output | 1 | Received word available |
| rx_ready_i | input | 1 | System accepts the received word |
| rx_word_o | output | 16 | Received word |
| rx_slot_o | output | SLOT_W | Slot number of the received word |
| tx_valid_i | input | 1 | System offers a transmit word |
| tx_ready_o | output | 1 | Transmit holding register empty |
| tx_word_i | input | 16 | Transmit word |
| tx_underrun_o | output | 1 | One-cycle pulse: slot started with no word held |
| sync_err_o | output | 1 | Sticky flag: frame sync seen inside a frame |

## Verification
The hardest situation to reach is a frame sync that lands inside a frame while a transmit word is partly shifted and a receive word is partly assembled. The recovery frame must then line up with the very next bit. The bench models the master bit by bit, so it can raise the sync on any chosen bit index. It places one such sync in the middle of slot 2 and starts the next frame's data on the following bit with no second sync. It then checks which words survive, the order in which transmit words are used, and that the error flag stays set through later clean frames. The serial input is also made invalid around each rising edge, so a port that sampled on the wrong edge would return corrupted words.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

  // Width of one audio sample word on the serial line.
  localparam int unsigned TDM_WORD_W = 16;

  // Synchronised view of the serial pins, one system clock per entry.
  typedef struct packed {
    logic rise;  // bit clock rising edge seen this cycle
    logic fall;  // bit clock falling edge seen this cycle
    logic fs;    // frame sync level aligned with the edge
    logic sd;    // serial input level aligned with the edge
  } tdm_pins_t;

endpackage

// File: rtl/tdm_pin_sync.sv
module tdm_pin_sync
  import tdm_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      bclk_i,
  input  logic      fsync_i,
  input  logic      sdin_i,
  output tdm_pins_t pins_o
);

  localparam int unsigned LAST = STAGES - 1;

  // Each stage carries {bclk, fsync, sdin} so all three stay aligned.
  logic [2:0] stg_q [STAGES];
  logic       bclk_prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= 3'b000;
        else         stg_q[i] <= {bclk_i, fsync_i, sdin_i};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= 3'b000;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) bclk_prev_q <= 1'b0;
    else         bclk_prev_q <= stg_q[LAST][2];
  end

  always_comb begin
    pins_o.rise = stg_q[LAST][2] & ~bclk_prev_q;
    pins_o.fall = ~stg_q[LAST][2] & bclk_prev_q;
    pins_o.fs   = stg_q[LAST][1];
    pins_o.sd   = stg_q[LAST][0];
  end

endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter int unsigned SLOTS  = 6,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              fs_i,
  output logic              active_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              samp_o,
  output logic              done_o,
  output logic              err_o
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);

  logic              active_q, active_n;
  logic [SLOT_W-1:0] slot_q,   slot_n;
  logic [BIT_W-1:0]  bit_q,    bit_n;
  logic              err_q,    err_n;
  logic              at_end;

  assign at_end = active_q && (slot_q == LAST_SLOT) && (bit_q == LAST_BIT);

  always_comb begin
    active_n = active_q;
    slot_n   = slot_q;
    bit_n    = bit_q;
    err_n    = err_q;
    samp_o   = 1'b0;
    done_o   = 1'b0;
    if (fall_i) begin
      if (active_q) begin
        if (fs_i && !at_end) begin
          err_n = 1'b1;             // sync inside a frame: drop partial word
        end else begin
          samp_o = 1'b1;
          done_o = (bit_q == LAST_BIT);
        end
      end
      if (fs_i) begin
        active_n = 1'b1;            // next falling edge samples slot 0 MSB
        slot_n   = '0;
        bit_n    = '0;
      end else if (active_q) begin
        if (bit_q == LAST_BIT) begin
          bit_n = '0;
          if (slot_q == LAST_SLOT) begin
            active_n = 1'b0;
            slot_n   = '0;
          end else begin
            slot_n = slot_q + SLOT_W'(1);
          end
        end else begin
          bit_n = bit_q + BIT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      active_q <= active_n;
      slot_q   <= slot_n;
      bit_q    <= bit_n;
      err_q    <= err_n;
    end
  end

  assign active_o = active_q;
  assign slot_o   = slot_q;
  assign bit_o    = bit_q;
  assign err_o    = err_q;

  // R1: slot index never leaves the frame
  p_slot_range_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    active_q |-> (slot_q <= LAST_SLOT));

  // R6: error flag is sticky
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    err_q |=> err_q);

  // R6 and R2: a sampled sync always restarts at slot 0, bit 0
  p_sync_restart_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (fall_i && fs_i) |=> (active_q && slot_q == '0 && bit_q == '0));

  // R4: without a sync the timer stays idle
  p_idle_stays_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (!active_q && !(fall_i && fs_i)) |=> !active_q);

endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              samp_i,
  input  logic              done_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              sd_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic [SLOT_W-1:0] slot_o
);

  logic [WORD_W-1:0] sh_q,    sh_n;
  logic [WORD_W-1:0] word_q,  word_n;
  logic [SLOT_W-1:0] slot_q,  slot_n;
  logic              valid_q, valid_n;
  logic [WORD_W-1:0] shifted;

  assign shifted = {sh_q[WORD_W-2:0], sd_i};

  always_comb begin
    sh_n    = sh_q;
    word_n  = word_q;
    slot_n  = slot_q;
    valid_n = valid_q;
    if (samp_i) sh_n = shifted;
    if (samp_i && done_i) begin
      word_n  = shifted;
      slot_n  = slot_i;
      valid_n = 1'b1;
    end else if (valid_q && ready_i) begin
      valid_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_n;
  end

  // Datapath registers: contents only matter while qualified by valid.
  always_ff @(posedge clk) begin
    sh_q   <= sh_n;
    word_q <= word_n;
    slot_q <= slot_n;
  end

  assign valid_o = valid_q;
  assign word_o  = word_q;
  assign slot_o  = slot_q;

  // R9: an offered word is held until accepted
  p_valid_hold_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> valid_q);

  // R9: held data stays put while waiting, unless a new word completes
  p_word_stable_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (valid_q && !ready_i && !(samp_i && done_i)) |=> ($stable(word_q) && $stable(slot_q)));

endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned BIT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              active_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ready_o,
  output logic              sd_o,
  output logic              underrun_o
);

  logic [WORD_W-1:0] hold_q, hold_n;
  logic              full_q, full_n;
  logic [WORD_W-1:0] sh_q,   sh_n;
  logic              sd_q,   sd_n;
  logic              ur_q,   ur_n;
  logic              load, shift;
  logic [WORD_W-1:0] word_sel;

  assign load     = rise_i && active_i && (bit_i == '0);
  assign shift    = rise_i && active_i && (bit_i != '0);
  assign word_sel = full_q ? hold_q : '0;

  always_comb begin
    full_n = full_q;
    hold_n = hold_q;
    sh_n   = sh_q;
    sd_n   = sd_q;
    ur_n   = 1'b0;
    if (load) full_n = 1'b0;
    if (valid_i && !full_q) begin
      full_n = 1'b1;
      hold_n = word_i;
    end
    if (load) begin
      sd_n = word_sel[WORD_W-1];
      sh_n = {word_sel[WORD_W-2:0], 1'b0};
      ur_n = !full_q;
    end else if (shift) begin
      sd_n = sh_q[WORD_W-1];
      sh_n = {sh_q[WORD_W-2:0], 1'b0};
    end else if (rise_i && !active_i) begin
      sd_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      sd_q   <= 1'b0;
      ur_q   <= 1'b0;
    end else begin
      full_q <= full_n;
      sd_q   <= sd_n;
      ur_q   <= ur_n;
    end
  end

  always_ff @(posedge clk) begin
    hold_q <= hold_n;
    sh_q   <= sh_n;
  end

  assign ready_o    = !full_q;
  assign sd_o       = sd_q;
  assign underrun_o = ur_q;

  // R3: serial output moves only after a rising bit clock edge
  p_sd_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    !rise_i |=> $stable(sd_q));

  // R7: an underrun slot starts with a zero bit
  p_underrun_zero_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    ur_q |-> !sd_q);

  // R8: an accepted word fills the holding register
  p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);

endmodule

// File: rtl/tdm_slave_port.sv
module tdm_slave_port
  import tdm_pkg::*;
#(
  parameter int unsigned SLOTS       = 6,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned WORD_W = TDM_WORD_W,
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              fsync_i,
  input  logic              sdin_i,
  output logic              sdout_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic [SLOT_W-1:0] rx_slot_o,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              tx_underrun_o,
  output logic              sync_err_o
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  tdm_pins_t         pins;
  logic              active;
  logic [SLOT_W-1:0] slot;
  logic [BIT_W-1:0]  bitn;
  logic              samp, done;

  tdm_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .bclk_i  (bclk_i),
    .fsync_i (fsync_i),
    .sdin_i  (sdin_i),
    .pins_o  (pins)
  );

  tdm_frame_timer #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_timer (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .fall_i   (pins.fall),
    .fs_i     (pins.fs),
    .active_o (active),
    .slot_o   (slot),
    .bit_o    (bitn),
    .samp_o   (samp),
    .done_o   (done),
    .err_o    (sync_err_o)
  );

  tdm_rx_deser #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_rx (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .samp_i  (samp),
    .done_i  (done),
    .slot_i  (slot),
    .sd_i    (pins.sd),
    .ready_i (rx_ready_i),
    .valid_o (rx_valid_o),
    .word_o  (rx_word_o),
    .slot_o  (rx_slot_o)
  );

  tdm_tx_ser #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_tx (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .rise_i     (pins.rise),
    .active_i   (active),
    .bit_i      (bitn),
    .valid_i    (tx_valid_i),
    .word_i     (tx_word_i),
    .ready_o    (tx_ready_o),
    .sd_o       (sdout_o),
    .underrun_o (tx_underrun_o)
  );

endmodule

// File: tb/tdm_slave_port_bench.sv
module tdm_slave_port_bench;

  localparam int SLOTS  = 6;
  localparam int W      = 16;
  localparam int SLOT_W = $clog2(SLOTS);

  logic clk = 1'b0;
  logic rst_n;
  logic bclk, fsync, sdin, sdout;
  logic rx_valid, rx_ready;
  logic [W-1:0] rx_word;
  logic [SLOT_W-1:0] rx_slot;
  logic tx_valid, tx_ready;
  logic [W-1:0] tx_word;
  logic tx_underrun, sync_err;

  always #2 clk = ~clk;  // 250 MHz

  tdm_slave_port #(.SLOTS(SLOTS)) u_tdm_slave_port (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fsync), .sdin_i(sdin),
    .sdout_o(sdout), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .rx_word_o(rx_word), .rx_slot_o(rx_slot), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .tx_word_i(tx_word), .tx_underrun_o(tx_underrun),
    .sync_err_o(sync_err)
  );

  int checks = 0;
  int errors = 0;
  int stab_bad = 0;
  int nlog = 0;
  int ur_cnt = 0;
  logic [W-1:0] logw [256];
  int           logs [256];
  logic [W-1:0] got  [SLOTS];
  bit feed_on = 0;
  int tx_idx = 0;
  bit prev_acc = 0;
  bit finished = 0;

  function automatic logic [W-1:0] rxpat(int f, int s);
    return W'((f * 16'h3C5A) ^ (s * 16'h1111) ^ 16'h8001);
  endfunction

  function automatic logic [W-1:0] txpat(int k);
    return W'(k * 16'h9E37 + 16'h0F0F);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitors sample away from the active edge.
  always @(negedge clk) begin
    if (rx_valid && rx_ready) begin
      logw[nlog % 256] = rx_word;
      logs[nlog % 256] = int'(rx_slot);
      nlog++;
    end
    if (tx_underrun) ur_cnt++;
  end

  // Transmit feeder: sequential words txpat(0), txpat(1), ...
  initial begin
    tx_valid = 1'b0;
    tx_word  = '0;
    forever begin
      @(negedge clk);
      if (prev_acc) tx_idx++;
      tx_valid = feed_on;
      tx_word  = txpat(tx_idx);
      prev_acc = tx_valid && tx_ready;
    end
  end

  // One bit period of the master: 16 system clocks. Input data is made
  // valid only in a window around the falling edge (R3 stress).
  task automatic bitclk(input logic fs, input logic d, output logic q);
    bclk = 1'b1; fsync = fs; sdin = ~d;
    repeat (3) @(negedge clk);
    sdin = d;
    repeat (5) @(negedge clk);
    bclk = 1'b0; q = sdout;
    repeat (4) @(negedge clk);
    if (sdout !== q) stab_bad++;
    sdin = ~d;
    repeat (4) @(negedge clk);
    if (sdout !== q) stab_bad++;
  endtask

  task automatic do_frame(input int fid, input bit lead, input bit tail, input int abort_at);
    logic q;
    if (lead) bitclk(1'b1, 1'b0, q);
    for (int s = 0; s < SLOTS; s++) begin
      logic [W-1:0] p = rxpat(fid, s);
      got[s] = '0;
      for (int b = 0; b < W; b++) begin
        int  idx = s * W + b;
        bit  last = (s == SLOTS - 1) && (b == W - 1);
        bitclk((tail && last) || (idx == abort_at), p[W-1-b], q);
        got[s][W-1-b] = q;
        if (idx == abort_at) return;
      end
    end
  endtask

  task automatic chk_tx(input string req, input int cons, input int n);
    for (int s = 0; s < n; s++)
      chk(got[s] == txpat(cons + s), req, int'(got[s]), int'(txpat(cons + s)));
  endtask

  task automatic chk_rx(input int at, input int fid, input int s0, input int n);
    for (int s = 0; s < n; s++) begin
      chk(logw[(at + s) % 256] == rxpat(fid, s0 + s), "R1 rx word",
          int'(logw[(at + s) % 256]), int'(rxpat(fid, s0 + s)));
      chk(logs[(at + s) % 256] == s0 + s, "R1 rx slot", logs[(at + s) % 256], s0 + s);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base, cons, ur0;
    logic q;
    rst_n = 1'b0; bclk = 1'b0; fsync = 1'b0; sdin = 1'b0; rx_ready = 1'b1;
    cons = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R10: reset state
    chk(rx_valid == 1'b0, "R10 rx_valid", int'(rx_valid), 0);
    chk(sdout == 1'b0, "R10 sdout", int'(sdout), 0);
    chk(tx_ready == 1'b1, "R10 tx_ready", int'(tx_ready), 1);
    chk(sync_err == 1'b0 && tx_underrun == 1'b0, "R10 flags",
        int'({sync_err, tx_underrun}), 0);

    @(posedge clk); #1 feed_on = 1;
    repeat (4) @(negedge clk);
    chk(tx_ready == 1'b0, "R8 ready low when holding full", int'(tx_ready), 0);

    // R4: bits without any frame sync
    base = nlog;
    begin
      int ones = 0;
      for (int i = 0; i < 20; i++) begin bitclk(1'b0, 1'b1, q); ones += int'(q); end
      chk(ones == 0, "R4 sdout idle before sync", ones, 0);
    end
    chk(nlog == base, "R4 no rx words before sync", nlog - base, 0);

    // R1 R2 R8: single frame
    base = nlog;
    do_frame(0, 1, 0, -1);
    repeat (40) @(negedge clk);
    chk(nlog - base == SLOTS, "R1 word count", nlog - base, SLOTS);
    chk_rx(base, 0, 0, SLOTS);
    chk_tx("R2 R8 tx words in order", cons, SLOTS);
    cons += SLOTS;

    // R4: idle after frame end without a new sync
    base = nlog;
    begin
      int ones = 0;
      for (int i = 0; i < 4; i++) begin bitclk(1'b0, 1'b1, q); ones += int'(q); end
      chk(ones == 0, "R4 sdout idle after frame", ones, 0);
    end
    chk(nlog == base, "R4 no rx words after frame", nlog - base, 0);

    // R5: back-to-back frames
    base = nlog;
    do_frame(1, 1, 1, -1);
    chk_tx("R5 tx frame A", cons, SLOTS);
    cons += SLOTS;
    do_frame(2, 0, 0, -1);
    chk_tx("R5 tx frame B", cons, SLOTS);
    cons += SLOTS;
    repeat (40) @(negedge clk);
    chk(nlog - base == 2 * SLOTS, "R5 word count", nlog - base, 2 * SLOTS);
    chk_rx(base, 1, 0, SLOTS);
    chk_rx(base + SLOTS, 2, 0, SLOTS);
    chk(sync_err == 1'b0, "R5 no sync error", int'(sync_err), 0);

    // R7: underrun
    @(posedge clk); #1 feed_on = 0;
    repeat (4) @(negedge clk);
    ur0 = ur_cnt;
    base = nlog;
    do_frame(3, 1, 0, -1);
    repeat (40) @(negedge clk);
    chk(got[0] == txpat(cons), "R7 held word still sent", int'(got[0]), int'(txpat(cons)));
    begin
      int nz = 0;
      for (int s = 1; s < SLOTS; s++) if (got[s] != '0) nz++;
      chk(nz == 0, "R7 empty slots send zero", nz, 0);
    end
    chk(ur_cnt - ur0 == SLOTS - 1, "R7 underrun pulses", ur_cnt - ur0, SLOTS - 1);
    chk_rx(base, 3, 0, SLOTS);
    cons += 1;
    @(posedge clk); #1 feed_on = 1;
    repeat (4) @(negedge clk);

    // R9: receive backpressure
    @(posedge clk); #1 rx_ready = 0;
    base = nlog;
    do_frame(4, 1, 0, -1);
    chk_tx("R8 tx after underrun", cons, SLOTS);
    cons += SLOTS;
    repeat (40) @(negedge clk);
    chk(rx_valid == 1'b1, "R9 valid held", int'(rx_valid), 1);
    chk(rx_word == rxpat(4, SLOTS - 1), "R9 newest word kept",
        int'(rx_word), int'(rxpat(4, SLOTS - 1)));
    chk(int'(rx_slot) == SLOTS - 1, "R9 newest slot kept", int'(rx_slot), SLOTS - 1);
    @(posedge clk); #1 rx_ready = 1;
    repeat (5) @(negedge clk);
    chk(nlog - base == 1, "R9 single word delivered", nlog - base, 1);
    chk(rx_valid == 1'b0, "R9 valid drops after accept", int'(rx_valid), 0);

    // R6: sync in the middle of slot 2, recovery with no further sync
    base = nlog;
    do_frame(5, 1, 0, 2 * W + 8);
    chk_tx("R6 tx before abort", cons, 2);
    cons += 3;
    do_frame(6, 0, 0, -1);
    chk_tx("R6 tx after restart", cons, SLOTS);
    cons += SLOTS;
    repeat (40) @(negedge clk);
    chk(sync_err == 1'b1, "R6 sync error set", int'(sync_err), 1);
    chk(nlog - base == 2 + SLOTS, "R6 partial word dropped", nlog - base, 2 + SLOTS);
    chk_rx(base, 5, 0, 2);
    chk_rx(base + 2, 6, 0, SLOTS);

    // R6: flag stays set across a clean frame
    base = nlog;
    do_frame(7, 1, 0, -1);
    chk_tx("R8 tx clean frame", cons, SLOTS);
    cons += SLOTS;
    repeat (40) @(negedge clk);
    chk(sync_err == 1'b1, "R6 sync error sticky", int'(sync_err), 1);
    chk_rx(base, 7, 0, SLOTS);

    // R3: serial output stable through every low phase
    chk(stab_bad == 0, "R3 sdout stable after rise", stab_bad, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule